// File: doc/BRIEF.md
# SD Host Command Launch and Status Register File

This block is the register front end of an SD/MMC host controller. Software writes a 32-bit command argument as two 16-bit halves, then writes a 16-bit command word. Writing the command word launches the command phase. The block decodes the command word into the fields that the command engine needs: opcode, response kind, busy expectation, command class, read direction, open-drain bus mode and an abort/initialize request.

The command and data engines report events on single-cycle pulse inputs. Each event sets a sticky status bit. Software clears a status bit by writing a one to its position. An interrupt enable register masks the status bits onto a single interrupt line.

A response timer is armed by every command that expects a response. If no response start is reported before the programmed number of clocks has passed, the timer raises the command timeout status bit. The timer limit resets to 64. The block also reports whether the most recent abort/initialize command ended cleanly.

Top module: `sdh_cmd_status`

## Requirements
- R1: A write to address 0 stores bits 31:16 of `cmd_arg`, and a write to address 1 stores bits 15:0. Both halves read back at their own addresses.
- R2: A write to address 2 (command word) raises `cmd_go` for exactly one cycle, in the cycle after the write edge. Writes to any other address never raise `cmd_go`.
- R3: The command word is decoded as follows, and it reads back unchanged at address 2:
  - opcode in bits 5:0;
  - open-drain in bit 6;
  - abort/initialize in bit 7;
  - response kind in bits 10:8 (0 = no response, 1 to 6 = R1 to R6);
  - busy-after-response in bit 11;
  - command class in bits 13:12 (0 broadcast, 1 broadcast with response, 2 addressed, 3 addressed with data);
  - read direction in bit 15.
- R4: The status register at address 3 has these sticky bits: 0 end of command, 5 data timeout, 6 data CRC error, 7 command timeout, 8 command CRC error, 14 card status error. Each bit is set by its event pulse and is visible after the next edge. All other bits read 0. Reset clears all bits.
- R5: Writing a 1 to an implemented status bit clears it. Writing a 0 leaves it unchanged.
- R6: When an event sets a status bit in the same cycle that a write clears that bit, the bit ends up set.
- R7: `irq` is the OR of the status bits ANDed with the interrupt enable register at address 4. Only the six status positions of the enable register are implemented (readback mask 0x41E1). The enable register resets to 0.
- R8: The response timeout limit at address 5 resets to 64 and is writable. Consider a command with a non-zero response kind and no `rsp_start`. Counting from the edge that captures the command write, status bit 7 becomes visible after limit+1 edges, and not one edge earlier.
- R9: No command timeout is raised in three cases:
  - `rsp_start` arrives before expiry;
  - the response kind is 0;
  - the limit is 0.
- R10: `init_ok` rises after an end-of-command event that completes a command with bit 7 set, provided no error status event (bits 5 to 8 or 14) occurred since that command's launch. `init_ok` clears on the next command launch.
- R11: Reading an unmapped address (6 or 7) returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for write and read |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Combinational read data for `reg_addr` |
| evt_cmd_end | input | 1 | Command phase ended |
| evt_data_tmo | input | 1 | Data timeout event |
| evt_data_crc | input | 1 | Data CRC error event |
| evt_cmd_crc | input | 1 | Command CRC error event |
| evt_card_err | input | 1 | Card status error event |
| rsp_start | input | 1 | Response start bit seen by the command engine |
| cmd_go | output | 1 | One-cycle command launch pulse |
| cmd_arg | output | 32 | Assembled command argument |
| cmd_index | output | 6 | Command opcode |
| rsp_kind | output | 3 | Expected response kind |
| rsp_busy | output | 1 | Busy expected after the response |
| cmd_kind | output | 2 | Command class |
| dat_read | output | 1 | Data transfer is a read |
| bus_od | output | 1 | Open-drain bus mode |
| abort_init | output | 1 | Abort/initialize request |
| init_ok | output | 1 | Last abort/initialize command ended cleanly |
| irq | output | 1 | Masked interrupt |

## Verification
A wrong status register state shows at `reg_rdata` and, when enabled, at `irq` one edge after the event or clear that caused it. Lost or phantom set/clear ordering is therefore visible on the next read. A wrong timer count shows as a command timeout bit that appears one edge early or late, or not at all, so the bench samples both the edge before and the edge of expected expiry. A decode slip shows immediately on the field outputs in the `cmd_go` cycle. A stale error tracker shows as a wrong `init_ok` level after the end-of-command edge.

// File: rtl/sdh_pkg.sv
package sdh_pkg;

    localparam int RW = 16;

    typedef enum logic [2:0] {
        RSP_NONE = 3'd0, RSP_R1 = 3'd1, RSP_R2 = 3'd2, RSP_R3 = 3'd3,
        RSP_R4 = 3'd4, RSP_R5 = 3'd5, RSP_R6 = 3'd6, RSP_BAD = 3'd7
    } rsp_e;

    typedef enum logic [1:0] {
        CK_BCAST = 2'd0, CK_BCAST_RSP = 2'd1, CK_ADDR = 2'd2, CK_ADDR_DATA = 2'd3
    } ckind_e;

    // Field order is the command word layout, msb first.
    typedef struct packed {
        logic       rd;
        logic       spare;
        ckind_e     kind;
        logic       busy;
        rsp_e       rsp;
        logic       abort;
        logic       od;
        logic [5:0] idx;
    } cmd_word_t;

    localparam logic [2:0] A_ARG_HI = 3'd0;
    localparam logic [2:0] A_ARG_LO = 3'd1;
    localparam logic [2:0] A_CMD    = 3'd2;
    localparam logic [2:0] A_STATUS = 3'd3;
    localparam logic [2:0] A_IRQ_EN = 3'd4;
    localparam logic [2:0] A_TMO    = 3'd5;

    localparam int B_EOC  = 0;
    localparam int B_DTO  = 5;
    localparam int B_DCRC = 6;
    localparam int B_CTO  = 7;
    localparam int B_CCRC = 8;
    localparam int B_CERR = 14;

    localparam logic [RW-1:0] ST_ERR_MASK = RW'((1 << B_DTO) | (1 << B_DCRC) |
                                                (1 << B_CTO) | (1 << B_CCRC) | (1 << B_CERR));
    localparam logic [RW-1:0] ST_MASK     = ST_ERR_MASK | RW'(1 << B_EOC);

    function automatic logic [RW-1:0] set_vector(input logic eoc, input logic dto,
                                                 input logic dcrc, input logic cto,
                                                 input logic ccrc, input logic cerr);
        logic [RW-1:0] v;
        v = '0;
        v[B_EOC]  = eoc;
        v[B_DTO]  = dto;
        v[B_DCRC] = dcrc;
        v[B_CTO]  = cto;
        v[B_CCRC] = ccrc;
        v[B_CERR] = cerr;
        return v;
    endfunction

endpackage

// File: rtl/sdh_cmd_launch.sv
module sdh_cmd_launch
    import sdh_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_hi,
    input  logic            wr_lo,
    input  logic            wr_cmd,
    input  logic [DW-1:0]   wdata,
    output logic [2*DW-1:0] arg,
    output cmd_word_t       cmd_q,
    output logic            go
);

    always_ff @(posedge clk) begin
        if (rst) begin
            arg   <= '0;
            cmd_q <= '0;
            go    <= 1'b0;
        end else begin
            go <= wr_cmd;
            if (wr_hi)  arg[2*DW-1:DW] <= wdata;
            if (wr_lo)  arg[DW-1:0]    <= wdata;
            if (wr_cmd) cmd_q          <= cmd_word_t'(wdata);
        end
    end

    // R2
    go_after_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        wr_cmd |=> go);

    // R2
    no_stray_go_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_cmd |=> !go);

    // R1
    arg_hi_chk: assert property (@(posedge clk) disable iff (rst)
        wr_hi |=> arg[2*DW-1:DW] == $past(wdata));

endmodule

// File: rtl/sdh_rsp_timer.sv
module sdh_rsp_timer #(
    parameter int TW        = 16,
    parameter int TMO_RESET = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_limit,
    input  logic [TW-1:0] wdata,
    input  logic          go,
    input  logic          rsp_none,
    input  logic          rsp_start,
    output logic [TW-1:0] limit,
    output logic          fire
);

    logic          armed;
    logic [TW-1:0] cnt;

    assign fire = armed && !rsp_start && (cnt == limit - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
            cnt   <= '0;
            limit <= TW'(TMO_RESET);
        end else begin
            if (wr_limit) limit <= wdata;
            if (go) begin
                armed <= !rsp_none && (limit != '0);
                cnt   <= '0;
            end else if (armed) begin
                if (rsp_start || fire) armed <= 1'b0;
                else                   cnt   <= cnt + 1'b1;
            end
        end
    end

    // R9
    rsp_stops_timer_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && rsp_start && !go) |=> !armed);

    // R8
    fire_disarms_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && !go) |=> !fire);

endmodule

// File: rtl/sdh_status_irq.sv
module sdh_status_irq
    import sdh_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_status,
    input  logic          wr_ie,
    input  logic [RW-1:0] wdata,
    input  logic          evt_eoc,
    input  logic          evt_dto,
    input  logic          evt_dcrc,
    input  logic          evt_cto,
    input  logic          evt_ccrc,
    input  logic          evt_cerr,
    input  logic          go,
    input  logic          abort_cmd,
    output logic [RW-1:0] status,
    output logic [RW-1:0] ie,
    output logic          irq,
    output logic          init_ok
);

    logic [RW-1:0] set_v, clr_v;
    logic          err_now, err_seen, init_pend;

    assign set_v   = set_vector(evt_eoc, evt_dto, evt_dcrc, evt_cto, evt_ccrc, evt_cerr);
    assign clr_v   = wr_status ? (wdata & ST_MASK) : '0;
    assign err_now = |(set_v & ST_ERR_MASK);
    assign irq     = |(status & ie);

    always_ff @(posedge clk) begin
        if (rst) begin
            status    <= '0;
            ie        <= '0;
            err_seen  <= 1'b0;
            init_pend <= 1'b0;
            init_ok   <= 1'b0;
        end else begin
            status <= ((status & ~clr_v) | set_v) & ST_MASK;
            if (wr_ie) ie <= wdata & ST_MASK;
            if (go) begin
                err_seen  <= 1'b0;
                init_pend <= abort_cmd;
                init_ok   <= 1'b0;
            end else begin
                err_seen <= err_seen | err_now;
                if (evt_eoc) begin
                    init_pend <= 1'b0;
                    if (init_pend && !err_seen && !err_now) init_ok <= 1'b1;
                end
            end
        end
    end

    // R5
    w1c_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_status && wdata[B_EOC] && !evt_eoc) |=> !status[B_EOC]);

    // R6
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_status && wdata[B_EOC] && evt_eoc) |=> status[B_EOC]);

    // R7
    irq_follows_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_dcrc && ie[B_DCRC] && !wr_ie) |=> irq);

    // R4
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (status[B_CERR] && !(wr_status && wdata[B_CERR])) |=> status[B_CERR]);

endmodule

// File: rtl/sdh_cmd_status.sv
module sdh_cmd_status
    import sdh_pkg::*;
#(
    parameter int TMO_W     = 16,
    parameter int TMO_RESET = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    input  logic        evt_cmd_end,
    input  logic        evt_data_tmo,
    input  logic        evt_data_crc,
    input  logic        evt_cmd_crc,
    input  logic        evt_card_err,
    input  logic        rsp_start,
    output logic        cmd_go,
    output logic [31:0] cmd_arg,
    output logic [5:0]  cmd_index,
    output logic [2:0]  rsp_kind,
    output logic        rsp_busy,
    output logic [1:0]  cmd_kind,
    output logic        dat_read,
    output logic        bus_od,
    output logic        abort_init,
    output logic        init_ok,
    output logic        irq
);

    cmd_word_t        cmd_q;
    logic [TMO_W-1:0] limit;
    logic [RW-1:0]    status, ie;
    logic             cto_fire;
    logic             wr_hi, wr_lo, wr_cmd, wr_status, wr_ie, wr_tmo;

    assign wr_hi     = reg_wr && (reg_addr == A_ARG_HI);
    assign wr_lo     = reg_wr && (reg_addr == A_ARG_LO);
    assign wr_cmd    = reg_wr && (reg_addr == A_CMD);
    assign wr_status = reg_wr && (reg_addr == A_STATUS);
    assign wr_ie     = reg_wr && (reg_addr == A_IRQ_EN);
    assign wr_tmo    = reg_wr && (reg_addr == A_TMO);

    sdh_cmd_launch #(.DW(RW)) u_launch (
        .clk(clk), .rst(rst), .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_cmd(wr_cmd),
        .wdata(reg_wdata), .arg(cmd_arg), .cmd_q(cmd_q), .go(cmd_go)
    );

    sdh_rsp_timer #(.TW(TMO_W), .TMO_RESET(TMO_RESET)) u_timer (
        .clk(clk), .rst(rst), .wr_limit(wr_tmo), .wdata(reg_wdata[TMO_W-1:0]),
        .go(cmd_go), .rsp_none(cmd_q.rsp == RSP_NONE), .rsp_start(rsp_start),
        .limit(limit), .fire(cto_fire)
    );

    sdh_status_irq u_status (
        .clk(clk), .rst(rst), .wr_status(wr_status), .wr_ie(wr_ie), .wdata(reg_wdata),
        .evt_eoc(evt_cmd_end), .evt_dto(evt_data_tmo), .evt_dcrc(evt_data_crc),
        .evt_cto(cto_fire), .evt_ccrc(evt_cmd_crc), .evt_cerr(evt_card_err),
        .go(cmd_go), .abort_cmd(cmd_q.abort),
        .status(status), .ie(ie), .irq(irq), .init_ok(init_ok)
    );

    assign cmd_index  = cmd_q.idx;
    assign rsp_kind   = cmd_q.rsp;
    assign rsp_busy   = cmd_q.busy;
    assign cmd_kind   = cmd_q.kind;
    assign dat_read   = cmd_q.rd;
    assign bus_od     = cmd_q.od;
    assign abort_init = cmd_q.abort;

    always_comb begin
        unique case (reg_addr)
            A_ARG_HI: reg_rdata = cmd_arg[31:16];
            A_ARG_LO: reg_rdata = cmd_arg[15:0];
            A_CMD:    reg_rdata = 16'(cmd_q);
            A_STATUS: reg_rdata = status;
            A_IRQ_EN: reg_rdata = ie;
            A_TMO:    reg_rdata = 16'(limit);
            default:  reg_rdata = 16'h0000;
        endcase
    end

endmodule

// File: tb/test_sdh_cmd_status.sv
`timescale 1ns/1ps
module test_sdh_cmd_status;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        evt_cmd_end = 0, evt_data_tmo = 0, evt_data_crc = 0;
    logic        evt_cmd_crc = 0, evt_card_err = 0, rsp_start = 0;
    logic        cmd_go, rsp_busy, dat_read, bus_od, abort_init, init_ok, irq;
    logic [31:0] cmd_arg;
    logic [5:0]  cmd_index;
    logic [2:0]  rsp_kind;
    logic [1:0]  cmd_kind;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    sdh_cmd_status i_sdh_cmd_status (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .evt_cmd_end(evt_cmd_end), .evt_data_tmo(evt_data_tmo),
        .evt_data_crc(evt_data_crc), .evt_cmd_crc(evt_cmd_crc),
        .evt_card_err(evt_card_err), .rsp_start(rsp_start),
        .cmd_go(cmd_go), .cmd_arg(cmd_arg), .cmd_index(cmd_index),
        .rsp_kind(rsp_kind), .rsp_busy(rsp_busy), .cmd_kind(cmd_kind),
        .dat_read(dat_read), .bus_od(bus_od), .abort_init(abort_init),
        .init_ok(init_ok), .irq(irq)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Pulses one event for one cycle; result is visible on return.
    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: evt_cmd_end  = 1'b1;
            1: evt_data_tmo = 1'b1;
            2: evt_data_crc = 1'b1;
            3: evt_cmd_crc  = 1'b1;
            4: evt_card_err = 1'b1;
            default: rsp_start = 1'b1;
        endcase
        @(negedge clk);
        {evt_cmd_end, evt_data_tmo, evt_data_crc, evt_cmd_crc, evt_card_err, rsp_start} = '0;
    endtask

    task automatic t_reset;
        logic [15:0] d;
        rd(3'd3, d); chk("R4", "status after reset", d, 16'h0);
        rd(3'd4, d); chk("R7", "irq enable after reset", d, 16'h0);
        rd(3'd5, d); chk("R8", "timeout limit after reset", d, 16'd64);
        chk("R7", "irq after reset", irq, 0);
        chk("R10", "init_ok after reset", init_ok, 0);
        chk("R2", "cmd_go after reset", cmd_go, 0);
    endtask

    task automatic t_default_timeout;
        logic [15:0] d;
        wr(3'd2, 16'h0101);
        waitn(64);
        rd(3'd3, d); chk("R8", "cto one edge before default expiry", d[7], 0);
        waitn(1);
        rd(3'd3, d); chk("R8", "cto at default expiry", d[7], 1);
        wr(3'd3, 16'hFFFF);
    endtask

    task automatic t_arg;
        logic [15:0] d;
        wr(3'd0, 16'hA5C3);
        chk("R2", "no go after arg-high write", cmd_go, 0);
        wr(3'd1, 16'h1234);
        chk("R2", "no go after arg-low write", cmd_go, 0);
        chk("R1", "assembled argument", cmd_arg, 32'hA5C31234);
        rd(3'd0, d); chk("R1", "arg high readback", d, 16'hA5C3);
        rd(3'd1, d); chk("R1", "arg low readback", d, 16'h1234);
    endtask

    task automatic t_decode;
        logic [15:0] d;
        wr(3'd2, 16'hBD51);
        chk("R2", "go in cycle after command write", cmd_go, 1);
        chk("R3", "opcode", cmd_index, 6'h11);
        chk("R3", "open-drain", bus_od, 1);
        chk("R3", "abort", abort_init, 0);
        chk("R3", "response kind", rsp_kind, 3'd5);
        chk("R3", "busy", rsp_busy, 1);
        chk("R3", "class", cmd_kind, 2'd3);
        chk("R3", "read", dat_read, 1);
        rd(3'd2, d); chk("R3", "command readback", d, 16'hBD51);
        waitn(1);
        chk("R2", "go lasts one cycle", cmd_go, 0);
        pulse(5);
        wr(3'd2, 16'h2385);
        chk("R3", "opcode 2", cmd_index, 6'h05);
        chk("R3", "abort 2", abort_init, 1);
        chk("R3", "response kind 2", rsp_kind, 3'd3);
        chk("R3", "class 2", cmd_kind, 2'd2);
        chk("R3", "read 2", dat_read, 0);
        chk("R3", "od/busy 2", {bus_od, rsp_busy}, 2'b00);
        pulse(5);
    endtask

    task automatic t_status;
        logic [15:0] d;
        wr(3'd3, 16'hFFFF);
        pulse(0); rd(3'd3, d); chk("R4", "end of command bit 0", d, 16'h0001);
        wr(3'd3, 16'hFFFF);
        pulse(1); rd(3'd3, d); chk("R4", "data timeout bit 5", d, 16'h0020);
        wr(3'd3, 16'hFFFF);
        pulse(2); rd(3'd3, d); chk("R4", "data crc bit 6", d, 16'h0040);
        wr(3'd3, 16'hFFFF);
        pulse(3); rd(3'd3, d); chk("R4", "command crc bit 8", d, 16'h0100);
        wr(3'd3, 16'hFFFF);
        pulse(4); rd(3'd3, d); chk("R4", "card error bit 14", d, 16'h4000);
        pulse(0); pulse(2); pulse(3);
        rd(3'd3, d); chk("R4", "sticky accumulation", d, 16'h4141);
        wr(3'd3, 16'h0041);
        rd(3'd3, d); chk("R5", "write-one clears", d, 16'h4100);
        wr(3'd3, 16'h0000);
        rd(3'd3, d); chk("R5", "write-zero keeps", d, 16'h4100);
        wr(3'd3, 16'hFFFF);
        rd(3'd3, d); chk("R5", "clear all", d, 16'h0000);
    endtask

    task automatic t_set_wins;
        logic [15:0] d;
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'd3; reg_wdata = 16'h0001; evt_cmd_end = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; evt_cmd_end = 1'b0;
        rd(3'd3, d); chk("R6", "set beats clear", d[0], 1);
        wr(3'd3, 16'hFFFF);
    endtask

    task automatic t_irq;
        logic [15:0] d;
        pulse(2);
        chk("R7", "irq masked when enable is 0", irq, 0);
        wr(3'd4, 16'h0040);
        chk("R7", "irq with enabled bit set", irq, 1);
        wr(3'd4, 16'h0001);
        chk("R7", "irq with other bit enabled", irq, 0);
        wr(3'd4, 16'hFFFF);
        rd(3'd4, d); chk("R7", "enable readback mask", d, 16'h41E1);
        wr(3'd3, 16'hFFFF);
        chk("R7", "irq drops after clear", irq, 0);
        wr(3'd4, 16'h0000);
    endtask

    task automatic t_timeout;
        logic [15:0] d;
        wr(3'd5, 16'd5);
        rd(3'd5, d); chk("R8", "limit readback", d, 16'd5);
        wr(3'd2, 16'h0101);
        waitn(5);
        rd(3'd3, d); chk("R8", "cto one edge before expiry", d[7], 0);
        waitn(1);
        rd(3'd3, d); chk("R8", "cto at expiry", d, 16'h0080);
        wr(3'd3, 16'hFFFF);
    endtask

    task automatic t_no_timeout;
        logic [15:0] d;
        wr(3'd2, 16'h0101);
        waitn(2);
        pulse(5);
        waitn(10);
        rd(3'd3, d); chk("R9", "response start prevents cto", d, 16'h0);
        wr(3'd2, 16'h0000);
        waitn(12);
        rd(3'd3, d); chk("R9", "no-response command arms no timer", d, 16'h0);
        wr(3'd5, 16'd0);
        wr(3'd2, 16'h0101);
        waitn(20);
        rd(3'd3, d); chk("R9", "limit zero disables timer", d, 16'h0);
    endtask

    task automatic t_init;
        wr(3'd2, 16'h0080);
        pulse(0);
        chk("R10", "clean abort/init completes", init_ok, 1);
        wr(3'd2, 16'h0080);
        waitn(1);
        chk("R10", "init_ok clears on next launch", init_ok, 0);
        pulse(3);
        pulse(0);
        chk("R10", "error blocks init_ok", init_ok, 0);
        wr(3'd2, 16'h0003);
        pulse(0);
        chk("R10", "plain command leaves init_ok low", init_ok, 0);
        wr(3'd3, 16'hFFFF);
    endtask

    task automatic t_unmapped;
        logic [15:0] d;
        rd(3'd6, d); chk("R11", "unmapped address 6", d, 16'h0);
        rd(3'd7, d); chk("R11", "unmapped address 7", d, 16'h0);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_default_timeout();
        t_arg();
        t_decode();
        t_status();
        t_set_wins();
        t_irq();
        t_timeout();
        t_no_timeout();
        t_init();
        t_unmapped();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

endmodule